// File: doc/BRIEF.md
# Address-Range Cacheability Filter

This block sits ahead of a cache lookup and decides, for every line-sized block an access touches, whether the access goes to the tag lookup or bypasses the cache. It holds a small table of inclusive address ranges loaded one entry at a time through a configuration port. The first accepted entry fixes the table's mode. Cacheable entries make the table an allow list: anything outside them is bypassed. Non-cacheable entries make it a deny list: anything inside them is bypassed. The two kinds never share the table.

An access is given as a start address and a byte count. The span from the address to address+size-1 is compared with every stored range, and any overlap at all counts as a match. The verdict is worked out once, when the request is accepted. It is then reported for each line block from the first block to the last, one block per cycle, and the first verdict appears one cycle after acceptance. Bypassed blocks add one each to a read or a write bypass counter, chosen by the access direction. Lookup blocks leave both counters unchanged. Configuration errors raise one-cycle flags, and the rejected entry is not stored.

Top module: `cacheability_filter`

## Requirements
- R1: After a synchronous reset, the table is empty, the mode is none, both bypass counters read 0, `vrd_valid` and all error flags are 0, and `req_ready` is 1.
- R2: With the mode at none, which means no stored entries, every block gets `vrd_bypass`=0, so it goes to lookup.
- R3: An entry whose start is greater than its end raises `err_order` in the cycle after it is presented, and the entry is not stored.
- R4: A non-cacheable entry (`cfg_noncache`=1) presented while the mode is allow, or a cacheable entry (`cfg_noncache`=0) presented while the mode is deny, raises `err_mix`, and the entry is not stored.
- R5: The table holds N_ENTRIES entries (8 by default). An entry presented to a full table raises `err_full` and is not stored.
- R6: An access span [lo, hi] matches a stored range [s, e] unless hi < s or lo > e. A single shared byte at either edge is a match.
- R7: In allow mode, an access that matches no stored range is bypassed, and one that matches any stored range goes to lookup.
- R8: In deny mode, an access that matches any stored range is bypassed, and all other accesses go to lookup.
- R9: An accepted request yields one verdict per line block, from block addr>>log2(LINE_BYTES) up to block (addr+size-1)>>log2(LINE_BYTES), on consecutive cycles. The first verdict comes one cycle after acceptance, and `req_ready` stays 0 until the last verdict is out.
- R10: Each bypassed block adds 1 to `rd_bypass_cnt` when `req_write`=0, or to `wr_bypass_cnt` when `req_write`=1. Lookup blocks change neither counter.
- R11: `cfg_clear` empties the table and returns the mode to none, so that entries of the other type can be loaded next. A configuration entry presented in the same cycle as the clear is dropped without raising any flag.
- R12: A request accepted in the same cycle as an entry load is judged against the table as it stood before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_clear | input | 1 | Empty the table and set the mode to none |
| cfg_valid | input | 1 | Present one range entry |
| cfg_noncache | input | 1 | Entry type: 1 = non-cacheable, 0 = cacheable |
| cfg_start | input | ADDR_W | Inclusive range start |
| cfg_end | input | ADDR_W | Inclusive range end |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Access start address |
| req_size | input | SIZE_W | Access size in bytes, at least 1 |
| vrd_valid | output | 1 | A block verdict is present |
| vrd_bypass | output | 1 | 1 = bypass the cache, 0 = go to lookup |
| vrd_write | output | 1 | Direction of the access the verdict belongs to |
| vrd_block | output | ADDR_W-log2(LINE_BYTES) | Line block number of the verdict |
| rd_bypass_cnt | output | CNT_W | Bypassed read blocks |
| wr_bypass_cnt | output | CNT_W | Bypassed write blocks |
| err_order | output | 1 | Last entry rejected: start greater than end |
| err_mix | output | 1 | Last entry rejected: type conflicts with the mode |
| err_full | output | 1 | Last entry rejected: table full |

## Verification
A table update and a verdict can fall in the same cycle: an entry load or a clear arrives on the edge where a request is accepted. The bench provokes this in a directed case, where a non-cacheable entry covering the requested address is loaded on the acceptance edge, and also at random during mixed traffic. The verdict is judged against the bench's model of the table as it stood before the load. The model applies the load only after that verdict is fixed, and the following request to the same address must then see the new entry.

// File: rtl/cf_pkg.sv
package cf_pkg;
   typedef enum logic [1:0] {
      MODE_NONE  = 2'd0,
      MODE_ALLOW = 2'd1,
      MODE_DENY  = 2'd2
   } cf_mode_e;
endpackage

// File: rtl/cf_range_table.sv
module cf_range_table
   import cf_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int N_ENTRIES = 8,
   localparam int FILL_W   = $clog2(N_ENTRIES + 1)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             cfg_clear,
   input  logic                             cfg_valid,
   input  logic                             cfg_noncache,
   input  logic [ADDR_W-1:0]                cfg_start,
   input  logic [ADDR_W-1:0]                cfg_end,
   output cf_mode_e                         mode,
   output logic [FILL_W-1:0]                fill,
   output logic [N_ENTRIES-1:0]             ent_valid,
   output logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_lo,
   output logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_hi,
   output logic                             err_order,
   output logic                             err_mix,
   output logic                             err_full
);
   logic bad_order, bad_mix, is_full, take;

   assign bad_order = cfg_start > cfg_end;
   assign bad_mix   = ((mode == MODE_ALLOW) && cfg_noncache) ||
                      ((mode == MODE_DENY) && !cfg_noncache);
   assign is_full   = fill == FILL_W'(N_ENTRIES);
   assign take      = cfg_valid && !bad_order && !bad_mix && !is_full;

   always_ff @(posedge clk) begin
      if (rst || cfg_clear) begin
         mode      <= MODE_NONE;
         fill      <= '0;
         ent_valid <= '0;
         ent_lo    <= '0;
         ent_hi    <= '0;
         err_order <= 1'b0;
         err_mix   <= 1'b0;
         err_full  <= 1'b0;
      end else begin
         err_order <= cfg_valid && bad_order;
         err_mix   <= cfg_valid && bad_mix;
         err_full  <= cfg_valid && is_full;
         if (take) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
               if (fill == FILL_W'(i)) begin
                  ent_valid[i] <= 1'b1;
                  ent_lo[i]    <= cfg_start;
                  ent_hi[i]    <= cfg_end;
               end
            end
            fill <= fill + FILL_W'(1);
            mode <= cfg_noncache ? MODE_DENY : MODE_ALLOW;
         end
      end
   end
endmodule

// File: rtl/cf_match.sv
module cf_match #(
   parameter int ADDR_W    = 32,
   parameter int N_ENTRIES = 8
) (
   input  logic [N_ENTRIES-1:0]             ent_valid,
   input  logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_lo,
   input  logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_hi,
   input  logic [ADDR_W-1:0]                acc_lo,
   input  logic [ADDR_W-1:0]                acc_hi,
   output logic                             any_hit
);
   logic [N_ENTRIES-1:0] hit_v;

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
      assign hit_v[i] = ent_valid[i] && !((acc_hi < ent_lo[i]) || (acc_lo > ent_hi[i]));
   end

   assign any_hit = |hit_v;
endmodule

// File: rtl/cf_block_seq.sv
module cf_block_seq #(
   parameter int BLK_W    = 28,
   parameter int CNT_W    = 64,
   parameter bit SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             write_in,
   input  logic             bypass_in,
   input  logic [BLK_W-1:0] first_blk,
   input  logic [BLK_W-1:0] last_blk,
   output logic             busy,
   output logic             vrd_valid,
   output logic             vrd_bypass,
   output logic             vrd_write,
   output logic [BLK_W-1:0] vrd_block,
   output logic [CNT_W-1:0] rd_cnt,
   output logic [CNT_W-1:0] wr_cnt
);
   logic [BLK_W-1:0] cur_q, last_q;
   logic             byp_q, wr_q;
   logic [CNT_W-1:0] rd_next, wr_next;
   logic             step_byp, step_wr, step;

   if (SATURATE) begin : g_sat
      assign rd_next = (&rd_cnt) ? rd_cnt : rd_cnt + CNT_W'(1);
      assign wr_next = (&wr_cnt) ? wr_cnt : wr_cnt + CNT_W'(1);
   end else begin : g_wrap
      assign rd_next = rd_cnt + CNT_W'(1);
      assign wr_next = wr_cnt + CNT_W'(1);
   end

   assign step     = start || busy;
   assign step_byp = start ? bypass_in : byp_q;
   assign step_wr  = start ? write_in : wr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy       <= 1'b0;
         vrd_valid  <= 1'b0;
         vrd_bypass <= 1'b0;
         vrd_write  <= 1'b0;
         vrd_block  <= '0;
         cur_q      <= '0;
         last_q     <= '0;
         byp_q      <= 1'b0;
         wr_q       <= 1'b0;
         rd_cnt     <= '0;
         wr_cnt     <= '0;
      end else begin
         vrd_valid <= step;
         if (start) begin
            vrd_block <= first_blk;
            cur_q     <= first_blk + BLK_W'(1);
            last_q    <= last_blk;
            byp_q     <= bypass_in;
            wr_q      <= write_in;
            busy      <= first_blk != last_blk;
         end else if (busy) begin
            vrd_block <= cur_q;
            cur_q     <= cur_q + BLK_W'(1);
            busy      <= cur_q != last_q;
         end
         if (step) begin
            vrd_bypass <= step_byp;
            vrd_write  <= step_wr;
            if (step_byp && step_wr)  wr_cnt <= wr_next;
            if (step_byp && !step_wr) rd_cnt <= rd_next;
         end
      end
   end
endmodule

// File: rtl/cacheability_filter.sv
module cacheability_filter
   import cf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 8,
   parameter int LINE_BYTES = 16,
   parameter int N_ENTRIES  = 8,
   parameter int CNT_W      = 64,
   parameter bit CNT_SAT    = 1'b0
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  cfg_clear,
   input  logic                                  cfg_valid,
   input  logic                                  cfg_noncache,
   input  logic [ADDR_W-1:0]                     cfg_start,
   input  logic [ADDR_W-1:0]                     cfg_end,
   input  logic                                  req_valid,
   output logic                                  req_ready,
   input  logic                                  req_write,
   input  logic [ADDR_W-1:0]                     req_addr,
   input  logic [SIZE_W-1:0]                     req_size,
   output logic                                  vrd_valid,
   output logic                                  vrd_bypass,
   output logic                                  vrd_write,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  vrd_block,
   output logic [CNT_W-1:0]                      rd_bypass_cnt,
   output logic [CNT_W-1:0]                      wr_bypass_cnt,
   output logic                                  err_order,
   output logic                                  err_mix,
   output logic                                  err_full
);
   localparam int LINE_SHIFT = $clog2(LINE_BYTES);
   localparam int BLK_W      = ADDR_W - LINE_SHIFT;
   localparam int FILL_W     = $clog2(N_ENTRIES + 1);

   initial begin
      assert (LINE_BYTES >= 1 && (1 << LINE_SHIFT) == LINE_BYTES)
         else $error("LINE_BYTES must be a power of two");
      assert (N_ENTRIES >= 1) else $error("N_ENTRIES must be at least 1");
      assert (SIZE_W < ADDR_W && LINE_SHIFT < ADDR_W)
         else $error("SIZE_W and line size must fit inside ADDR_W");
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
   end

   cf_mode_e                         mode_q;
   logic [FILL_W-1:0]                fill_q;
   logic [N_ENTRIES-1:0]             ent_valid;
   logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_lo, ent_hi;
   logic [ADDR_W-1:0]                acc_lo, acc_hi;
   logic                             any_hit, bypass, accept, busy;

   cf_range_table #(.ADDR_W(ADDR_W), .N_ENTRIES(N_ENTRIES)) u_table (
      .clk          (clk),
      .rst          (rst),
      .cfg_clear    (cfg_clear),
      .cfg_valid    (cfg_valid),
      .cfg_noncache (cfg_noncache),
      .cfg_start    (cfg_start),
      .cfg_end      (cfg_end),
      .mode         (mode_q),
      .fill         (fill_q),
      .ent_valid    (ent_valid),
      .ent_lo       (ent_lo),
      .ent_hi       (ent_hi),
      .err_order    (err_order),
      .err_mix      (err_mix),
      .err_full     (err_full)
   );

   assign acc_lo = req_addr;
   assign acc_hi = req_addr + ADDR_W'(req_size) - ADDR_W'(1);

   cf_match #(.ADDR_W(ADDR_W), .N_ENTRIES(N_ENTRIES)) u_match (
      .ent_valid (ent_valid),
      .ent_lo    (ent_lo),
      .ent_hi    (ent_hi),
      .acc_lo    (acc_lo),
      .acc_hi    (acc_hi),
      .any_hit   (any_hit)
   );

   always_comb begin
      unique case (mode_q)
         MODE_ALLOW: bypass = !any_hit;
         MODE_DENY:  bypass = any_hit;
         default:    bypass = 1'b0;
      endcase
   end

   assign req_ready = !busy;
   assign accept    = req_valid && !busy;

   cf_block_seq #(.BLK_W(BLK_W), .CNT_W(CNT_W), .SATURATE(CNT_SAT)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (accept),
      .write_in   (req_write),
      .bypass_in  (bypass),
      .first_blk  (acc_lo[ADDR_W-1:LINE_SHIFT]),
      .last_blk   (acc_hi[ADDR_W-1:LINE_SHIFT]),
      .busy       (busy),
      .vrd_valid  (vrd_valid),
      .vrd_bypass (vrd_bypass),
      .vrd_write  (vrd_write),
      .vrd_block  (vrd_block),
      .rd_cnt     (rd_bypass_cnt),
      .wr_cnt     (wr_bypass_cnt)
   );
endmodule

// File: rtl/cf_checker.sv
module cf_checker #(
   parameter int BLK_W     = 28,
   parameter int CNT_W     = 64,
   parameter int FILL_W    = 4,
   parameter int N_ENTRIES = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic              vrd_valid,
   input logic              vrd_bypass,
   input logic              vrd_write,
   input logic [BLK_W-1:0]  vrd_block,
   input logic [CNT_W-1:0]  rd_cnt,
   input logic [CNT_W-1:0]  wr_cnt,
   input logic [1:0]        mode,
   input logic [FILL_W-1:0] fill,
   input logic              err_order,
   input logic              err_mix,
   input logic              err_full
);
   AST_EMPTY_LOOKUP: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd0 && req_valid && req_ready) |=> !vrd_bypass); // R2

   AST_ORDER_NO_STORE: assert property (@(posedge clk) disable iff (rst)
      err_order |-> fill == $past(fill)); // R3

   AST_MIX_NO_STORE: assert property (@(posedge clk) disable iff (rst)
      err_mix |-> fill == $past(fill)); // R4

   AST_FULL_NO_STORE: assert property (@(posedge clk) disable iff (rst)
      err_full |-> (fill == FILL_W'(N_ENTRIES)) && (fill == $past(fill))); // R5

   AST_ACCEPT_VERDICT: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> vrd_valid); // R9

   AST_BUSY_VERDICT: assert property (@(posedge clk) disable iff (rst)
      !req_ready |=> vrd_valid); // R9

   AST_BLOCK_STEP: assert property (@(posedge clk) disable iff (rst)
      (vrd_valid && !$past(req_ready)) |-> vrd_block == $past(vrd_block) + BLK_W'(1)); // R9

   AST_RD_COUNT: assert property (@(posedge clk) disable iff (rst)
      (vrd_valid && vrd_bypass && !vrd_write) |->
         (rd_cnt == $past(rd_cnt) + CNT_W'(1)) && (wr_cnt == $past(wr_cnt))); // R10

   AST_WR_COUNT: assert property (@(posedge clk) disable iff (rst)
      (vrd_valid && vrd_bypass && vrd_write) |->
         (wr_cnt == $past(wr_cnt) + CNT_W'(1)) && (rd_cnt == $past(rd_cnt))); // R10

   AST_LOOKUP_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
      (vrd_valid && !vrd_bypass) |-> $stable(rd_cnt) && $stable(wr_cnt)); // R10
endmodule

bind cacheability_filter cf_checker #(
   .BLK_W     (BLK_W),
   .CNT_W     (CNT_W),
   .FILL_W    (FILL_W),
   .N_ENTRIES (N_ENTRIES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .vrd_valid  (vrd_valid),
   .vrd_bypass (vrd_bypass),
   .vrd_write  (vrd_write),
   .vrd_block  (vrd_block),
   .rd_cnt     (rd_bypass_cnt),
   .wr_cnt     (wr_bypass_cnt),
   .mode       (mode_q),
   .fill       (fill_q),
   .err_order  (err_order),
   .err_mix    (err_mix),
   .err_full   (err_full)
);

// File: tb/cacheability_filter_tb.sv
module cacheability_filter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int SW = 8;
   localparam int LB = 16;
   localparam int LS = 4;
   localparam int NE = 8;
   localparam int CW = 64;
   localparam int BW = AW - LS;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          rst = 1'b1;
   logic          cfg_clear = 1'b0, cfg_valid = 1'b0, cfg_noncache = 1'b0;
   logic [AW-1:0] cfg_start = '0, cfg_end = '0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_size = 8'd1;
   logic          req_ready, vrd_valid, vrd_bypass, vrd_write;
   logic [BW-1:0] vrd_block;
   logic [CW-1:0] rd_bypass_cnt, wr_bypass_cnt;
   logic          err_order, err_mix, err_full;

   cacheability_filter #(
      .ADDR_W(AW), .SIZE_W(SW), .LINE_BYTES(LB), .N_ENTRIES(NE), .CNT_W(CW), .CNT_SAT(1'b0)
   ) dut_i (
      .clk(clk), .rst(rst), .cfg_clear(cfg_clear), .cfg_valid(cfg_valid),
      .cfg_noncache(cfg_noncache), .cfg_start(cfg_start), .cfg_end(cfg_end),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .vrd_valid(vrd_valid),
      .vrd_bypass(vrd_bypass), .vrd_write(vrd_write), .vrd_block(vrd_block),
      .rd_bypass_cnt(rd_bypass_cnt), .wr_bypass_cnt(wr_bypass_cnt),
      .err_order(err_order), .err_mix(err_mix), .err_full(err_full)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   int cyc   = 0;

   // reference model: mode 0 none, 1 allow, 2 deny
   logic [AW-1:0] m_st [NE];
   logic [AW-1:0] m_en [NE];
   int            m_fill = 0;
   int            m_mode = 0;
   logic [CW-1:0] exp_rd = '0, exp_wr = '0;

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic bit ref_byp(logic [AW-1:0] lo, logic [AW-1:0] hi);
      bit any = 1'b0;
      for (int i = 0; i < m_fill; i++)
         if (!((hi < m_st[i]) || (lo > m_en[i]))) any = 1'b1;
      if (m_mode == 1) return !any;
      if (m_mode == 2) return any;
      return 1'b0;
   endfunction

   // checks flags of an entry presented on the last edge, then updates model
   task automatic cfg_post(bit nc, logic [AW-1:0] st, logic [AW-1:0] en);
      bit eo, em, ef;
      eo = st > en;
      em = (m_mode == 1 && nc) || (m_mode == 2 && !nc);
      ef = m_fill == NE;
      chk("R3 err_order", {63'd0, err_order}, {63'd0, eo});
      chk("R4 err_mix",   {63'd0, err_mix},   {63'd0, em});
      chk("R5 err_full",  {63'd0, err_full},  {63'd0, ef});
      if (!eo && !em && !ef) begin
         m_st[m_fill] = st;
         m_en[m_fill] = en;
         m_fill++;
         m_mode = nc ? 2 : 1;
      end
   endtask

   task automatic do_cfg(bit nc, logic [AW-1:0] st, logic [AW-1:0] en);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_noncache = nc; cfg_start = st; cfg_end = en;
      @(negedge clk);
      cfg_valid = 1'b0;
      cfg_post(nc, st, en);
   endtask

   task automatic do_clear();
      @(negedge clk);
      cfg_clear = 1'b1;
      cfg_valid = 1'b1; cfg_noncache = 1'b1; cfg_start = 32'h10; cfg_end = 32'h0;
      @(negedge clk);
      cfg_clear = 1'b0; cfg_valid = 1'b0;
      m_fill = 0; m_mode = 0;
      chk("R11 no flag on clear", {61'd0, err_order, err_mix, err_full}, 64'd0);
   endtask

   task automatic do_req(bit wr, logic [AW-1:0] addr, int size, string tag,
                         bit with_cfg = 1'b0, bit nc = 1'b0,
                         logic [AW-1:0] st = '0, logic [AW-1:0] en = '0);
      logic [AW-1:0] hi;
      logic [BW-1:0] f, l;
      bit            b;
      hi = addr + AW'(size) - 1;
      f  = addr[AW-1:LS];
      l  = hi[AW-1:LS];
      b  = ref_byp(addr, hi);
      @(negedge clk);
      chk("R9 idle vrd_valid", {63'd0, vrd_valid}, 64'd0);
      chk("R9 ready when idle", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = SW'(size);
      if (with_cfg) begin
         cfg_valid = 1'b1; cfg_noncache = nc; cfg_start = st; cfg_end = en;
      end
      @(negedge clk);
      req_valid = 1'b0; cfg_valid = 1'b0;
      if (with_cfg) cfg_post(nc, st, en);
      for (int k = 0; k <= int'(l - f); k++) begin
         chk("R9 vrd_valid", {63'd0, vrd_valid}, 64'd1);
         chk("R9 vrd_block", 64'(vrd_block), 64'(f + BW'(k)));
         chk({tag, " verdict"}, {63'd0, vrd_bypass}, {63'd0, b});
         chk("R10 vrd_write", {63'd0, vrd_write}, {63'd0, wr});
         if (b) begin
            if (wr) exp_wr++;
            else    exp_rd++;
         end
         chk("R10 read bypass count", rd_bypass_cnt, exp_rd);
         chk("R10 write bypass count", wr_bypass_cnt, exp_wr);
         if (k < int'(l - f)) begin
            chk("R9 ready low while busy", {63'd0, req_ready}, 64'd0);
            @(negedge clk);
         end
      end
   endtask

   function automatic string mode_tag();
      if (m_mode == 1) return "R7";
      if (m_mode == 2) return "R8";
      return "R2";
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog R9: actual %0d cycles expected fewer", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 ready", {63'd0, req_ready}, 64'd1);
      chk("R1 vrd_valid", {63'd0, vrd_valid}, 64'd0);
      chk("R1 rd count", rd_bypass_cnt, 64'd0);
      chk("R1 wr count", wr_bypass_cnt, 64'd0);
      chk("R1 flags", {61'd0, err_order, err_mix, err_full}, 64'd0);

      // R2 empty table
      do_req(1'b0, 32'h2000, 4, "R2");
      do_req(1'b1, 32'h1ff8, 40, "R2");

      // R7 allow list, R6 overlap edges
      do_cfg(1'b0, 32'h1000, 32'h1fff);
      do_cfg(1'b0, 32'h3000, 32'h3fff);
      do_req(1'b0, 32'h1000, 16, "R7");
      do_req(1'b0, 32'h2000, 16, "R7");
      do_req(1'b0, 32'h3ff8, 16, "R6");
      do_req(1'b0, 32'h0ff8, 8, "R6");
      do_req(1'b0, 32'h0ff9, 8, "R6");
      do_req(1'b1, 32'h5000, 33, "R10");

      // R4 mix rejected, not stored
      do_cfg(1'b1, 32'h6000, 32'h60ff);
      do_req(1'b0, 32'h6000, 4, "R4");
      // R3 order rejected, not stored
      do_cfg(1'b0, 32'h7100, 32'h7000);
      do_req(1'b0, 32'h7080, 4, "R3");
      // R5 fill the table then overflow
      for (int i = 0; i < 6; i++) do_cfg(1'b0, 32'h8000 + 32'(i) * 32'h100, 32'h80ff + 32'(i) * 32'h100);
      do_cfg(1'b0, 32'h9000, 32'h90ff);
      do_req(1'b0, 32'h9000, 4, "R5");
      do_req(1'b1, 32'h8500, 4, "R5");

      // R11 clear, then deny list, R8
      do_clear();
      do_req(1'b0, 32'h2000, 4, "R11");
      do_cfg(1'b1, 32'h1000, 32'h1fff);
      do_cfg(1'b1, 32'h3000, 32'h3fff);
      do_req(1'b0, 32'h1800, 4, "R8");
      do_req(1'b1, 32'h2800, 4, "R8");
      do_req(1'b1, 32'h2ff0, 17, "R8");

      // R12 load and request on the same edge
      do_req(1'b0, 32'h4000, 4, "R12", 1'b1, 1'b1, 32'h4000, 32'h40ff);
      do_req(1'b0, 32'h4000, 4, "R12");

      // constrained random traffic
      for (int it = 0; it < 400; it++) begin
         int r;
         r = int'($urandom % 20);
         if (r == 0) begin
            do_clear();
         end else if (r < 5) begin
            bit nc;
            logic [AW-1:0] st, en;
            nc = (m_mode == 0) ? 1'($urandom % 2) : (m_mode == 2);
            if ($urandom % 8 == 0) nc = !nc;
            st = 32'($urandom % 32'hF000);
            en = st + 32'($urandom % 32'h800);
            if ($urandom % 8 == 0) begin
               logic [AW-1:0] t;
               t = st; st = en + 1; en = t;
            end
            do_cfg(nc, st, en);
         end else begin
            bit wr;
            logic [AW-1:0] a;
            int sz;
            wr = 1'($urandom % 2);
            a  = 32'($urandom % 32'hFF00);
            sz = 1 + int'($urandom % 48);
            if (r == 19)
               do_req(wr, a, sz, {mode_tag(), " R12"}, 1'b1, (m_mode == 2),
                      a & 32'hFFFF_FF00, (a & 32'hFFFF_FF00) + 32'hFF);
            else
               do_req(wr, a, sz, mode_tag());
         end
      end

      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule